// File: doc/BRIEF.md
# Segment Table Address Translator

The block turns a logical address, given as a segment number and an offset inside that segment, into a physical address. It holds a small table of segment descriptors in flip-flops. Each descriptor has a base address, a length (limit), a valid bit, read/write/execute permission bits and two status bits: referenced and modified. A separate segment-count register bounds which segment numbers are legal. For every request the block checks the segment number against the count, the valid bit, the offset against the limit and the access kind against the permissions. If all pass, it adds base and offset and updates the status bits. Otherwise it returns a fault with a cause code.

Requests enter on a valid/ready channel and results leave on a valid/ready channel with one output register between them. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in that same cycle. When `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and no new request is taken.

Descriptors and the count are loaded through plain write strobes. The status bits of any entry can be read combinationally through a separate index.

Top module: `seg_xlat`

## Requirements
- R1: After reset the response channel is empty (`rsp_valid`=0, `req_ready`=1), the segment count is 0, and every entry is invalid with clear referenced and modified bits.
- R2: A request with segment number greater than or equal to the segment count gets cause 1 (bad segment). This cause wins over all others.
- R3: A legal segment number whose entry has its valid bit clear gets cause 2 (invalid). This wins over limit and permission faults.
- R4: An offset greater than or equal to the entry limit gets cause 3 (limit). This wins over a permission fault. The limit has one more bit than the offset, so a limit of 2^OFF_W admits every offset.
- R5: Access kind 0=read needs perm bit 0, 1=write needs perm bit 1, and 2=execute needs perm bit 2. Kind 3 is never permitted. A missing permission gets cause 4.
- R6: A request with no fault returns cause 0, `rsp_fault`=0 and `rsp_paddr` = base + offset modulo 2^PA_W. A faulted response has `rsp_fault`=1 and `rsp_paddr`=0.
- R7: A request accepted without fault sets the entry's referenced bit. If it is a write it also sets the modified bit. A faulted request changes no status bit.
- R8: A request accepted on an edge appears on `rsp_valid` right after that edge. Responses are issued in acceptance order. `req_ready` equals `!rsp_valid || rsp_ready`.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold their values on the next cycle.
- R10: A descriptor write or a count write on the same edge as an accepted request does not affect that request, which sees the old contents. The written entry takes the new fields with referenced and modified cleared, and the write wins over any status update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_we | input | 1 | Load the segment-count register |
| cnt_val | input | SEG_W+1 | New segment count |
| cfg_we | input | 1 | Load one descriptor |
| cfg_idx | input | SEG_W | Descriptor index to load |
| cfg_base | input | PA_W | Segment base address |
| cfg_limit | input | OFF_W+1 | Segment length |
| cfg_valid | input | 1 | Descriptor valid bit |
| cfg_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| stat_idx | input | SEG_W | Entry whose status bits are shown |
| stat_ref | output | 1 | Referenced bit of entry `stat_idx` |
| stat_mod | output | 1 | Modified bit of entry `stat_idx` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 3 | 0 none, 1 bad segment, 2 invalid, 3 limit, 4 permission |

## Verification
The collision that matters is a descriptor or count write landing on the same edge as an accepted translation of that same segment. In that case the translation and the status-bit update both compete with the write. The bench provokes this with a directed write-access request while it rewrites the entry's base, then repeats it with a count write. Its random phase also issues descriptor writes and requests to overlapping indices on the same edges. Each result is judged against a bench model that computes the response from the table before the write and then applies the write with cleared status bits. The readback of referenced and modified bits then confirms that the write won.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_BADSEG  = 3'd1,
    CAUSE_INVALID = 3'd2,
    CAUSE_LIMIT   = 3'd3,
    CAUSE_PERM    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_N  = 3;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlat_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEG_W-1:0]   wr_idx,
  input  logic [PA_W-1:0]    wr_base,
  input  logic [OFF_W:0]     wr_limit,
  input  logic               wr_valid,
  input  logic [PERM_N-1:0]  wr_perm,
  input  logic [SEG_W-1:0]   rd_idx,
  output logic [PA_W-1:0]    rd_base,
  output logic [OFF_W:0]     rd_limit,
  output logic               rd_valid,
  output logic [PERM_N-1:0]  rd_perm,
  input  logic               upd_en,
  input  logic [SEG_W-1:0]   upd_idx,
  input  logic               upd_write,
  input  logic [SEG_W-1:0]   stat_idx,
  output logic               stat_ref,
  output logic               stat_mod
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0]   base_q  [NSEG];
  logic [OFF_W:0]    limit_q [NSEG];
  logic [PERM_N-1:0] perm_q  [NSEG];
  logic [NSEG-1:0]   vld_q;
  logic [NSEG-1:0]   ref_q;
  logic [NSEG-1:0]   mod_q;

  // Descriptor write has priority over the status update of the same entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        perm_q[i]  <= '0;
      end
      vld_q <= '0;
      ref_q <= '0;
      mod_q <= '0;
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        if (wr_en && wr_idx == SEG_W'(i)) begin
          base_q[i]  <= wr_base;
          limit_q[i] <= wr_limit;
          perm_q[i]  <= wr_perm;
          vld_q[i]   <= wr_valid;
          ref_q[i]   <= 1'b0;
          mod_q[i]   <= 1'b0;
        end else if (upd_en && upd_idx == SEG_W'(i)) begin
          ref_q[i] <= 1'b1;
          if (upd_write) mod_q[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_base  = base_q[rd_idx];
    rd_limit = limit_q[rd_idx];
    rd_perm  = perm_q[rd_idx];
    rd_valid = vld_q[rd_idx];
    stat_ref = ref_q[stat_idx];
    stat_mod = mod_q[stat_idx];
  end

  assert_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(wr_en && wr_idx == upd_idx)) |=> ref_q[$past(upd_idx)]);

  assert_mod_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_write && !(wr_en && wr_idx == upd_idx)) |=> mod_q[$past(upd_idx)]);

  assert_wr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!ref_q[$past(wr_idx)] && !mod_q[$past(wr_idx)]));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SEG_W-1:0]   seg,
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         kind,
  input  logic [SEG_W:0]     seg_count,
  input  logic [PA_W-1:0]    base,
  input  logic [OFF_W:0]     limit,
  input  logic               ent_valid,
  input  logic [PERM_N-1:0]  perm,
  output cause_e             cause,
  output logic [PA_W-1:0]    paddr
);
  logic seg_bad, off_bad, perm_ok;

  always_comb begin
    seg_bad = ({1'b0, seg} >= seg_count);
    off_bad = ({1'b0, off} >= limit);
    case (acc_e'(kind))
      ACC_READ:  perm_ok = perm[PERM_RD];
      ACC_WRITE: perm_ok = perm[PERM_WR];
      ACC_EXEC:  perm_ok = perm[PERM_EX];
      default:   perm_ok = 1'b0;
    endcase
  end

  // Fixed priority of fault causes.
  always_comb begin
    if (seg_bad)         cause = CAUSE_BADSEG;
    else if (!ent_valid) cause = CAUSE_INVALID;
    else if (off_bad)    cause = CAUSE_LIMIT;
    else if (!perm_ok)   cause = CAUSE_PERM;
    else                 cause = CAUSE_NONE;
  end

  always_comb begin
    paddr = '0;
    if (cause == CAUSE_NONE) paddr = base + PA_W'(off);
  end

  assert_badseg_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && {1'b0, seg} >= seg_count) |-> cause == CAUSE_BADSEG);

  assert_in_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cause == CAUSE_NONE) |-> ({1'b0, off} < limit && ent_valid));
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
  import seg_xlat_pkg::*;
#(
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_fire,
  input  cause_e          in_cause,
  input  logic [PA_W-1:0] in_paddr,
  output logic            in_ready,
  output logic            out_valid,
  input  logic            out_ready,
  output cause_e          out_cause,
  output logic [PA_W-1:0] out_paddr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cause <= CAUSE_NONE;
      out_paddr <= '0;
    end else if (in_ready) begin
      out_valid <= in_fire;
      if (in_fire) begin
        out_cause <= in_cause;
        out_paddr <= in_paddr;
      end
    end
  end

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cause) && $stable(out_paddr)));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cause != CAUSE_NONE) |-> out_paddr == '0);
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_we,
  input  logic [SEG_W:0]     cnt_val,
  input  logic               cfg_we,
  input  logic [SEG_W-1:0]   cfg_idx,
  input  logic [PA_W-1:0]    cfg_base,
  input  logic [OFF_W:0]     cfg_limit,
  input  logic               cfg_valid,
  input  logic [2:0]         cfg_perm,
  input  logic [SEG_W-1:0]   stat_idx,
  output logic               stat_ref,
  output logic               stat_mod,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [1:0]         req_kind,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic [2:0]         rsp_cause
);
  logic [SEG_W:0]    count_q;
  logic [PA_W-1:0]   ent_base;
  logic [OFF_W:0]    ent_limit;
  logic              ent_valid;
  logic [PERM_N-1:0] ent_perm;
  cause_e            chk_cause;
  logic [PA_W-1:0]   chk_paddr;
  logic              fire;
  cause_e            out_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_we) count_q <= cnt_val;
  end

  assign fire = req_valid && req_ready;

  seg_desc_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_base   (cfg_base),
    .wr_limit  (cfg_limit),
    .wr_valid  (cfg_valid),
    .wr_perm   (cfg_perm),
    .rd_idx    (req_seg),
    .rd_base   (ent_base),
    .rd_limit  (ent_limit),
    .rd_valid  (ent_valid),
    .rd_perm   (ent_perm),
    .upd_en    (fire && chk_cause == CAUSE_NONE),
    .upd_idx   (req_seg),
    .upd_write (req_kind == ACC_WRITE),
    .stat_idx  (stat_idx),
    .stat_ref  (stat_ref),
    .stat_mod  (stat_mod)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fire),
    .seg       (req_seg),
    .off       (req_off),
    .kind      (req_kind),
    .seg_count (count_q),
    .base      (ent_base),
    .limit     (ent_limit),
    .ent_valid (ent_valid),
    .perm      (ent_perm),
    .cause     (chk_cause),
    .paddr     (chk_paddr)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (fire),
    .in_cause  (chk_cause),
    .in_paddr  (chk_paddr),
    .in_ready  (req_ready),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_cause (out_cause),
    .out_paddr (rsp_paddr)
  );

  assign rsp_cause = out_cause;
  assign rsp_fault = (out_cause != CAUSE_NONE);

  assert_count_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count_q == $past(cnt_val));
endmodule

// File: tb/sim_seg_xlat.sv
`timescale 1ns/1ps
module sim_seg_xlat;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int NSEG  = 1 << SEG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_we = 1'b0;
  logic [SEG_W:0] cnt_val = '0;
  logic cfg_we = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [OFF_W:0] cfg_limit = '0;
  logic cfg_valid = 1'b0;
  logic [2:0] cfg_perm = '0;
  logic [SEG_W-1:0] stat_idx = '0;
  logic stat_ref, stat_mod;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [PA_W-1:0] rsp_paddr;
  logic rsp_fault;
  logic [2:0] rsp_cause;

  always #2.5 clk = ~clk;

  seg_xlat #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u0 (.*);

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [PA_W-1:0] mbase [NSEG];
  logic [OFF_W:0]  mlim  [NSEG];
  logic [2:0]      mperm [NSEG];
  logic            mval  [NSEG];
  logic            mref  [NSEG];
  logic            mmod  [NSEG];
  logic [SEG_W:0]  mcnt;
  logic [PA_W+2:0] expq [$];
  bit              last_fire, prev_stall;
  logic [PA_W-1:0] prev_paddr;
  logic [2:0]      prev_cause;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cause(input logic [SEG_W-1:0] s,
      input logic [OFF_W-1:0] o, input logic [1:0] k);
    bit pok;
    pok = (k == 2'd0) ? mperm[s][0] : (k == 2'd1) ? mperm[s][1] :
          (k == 2'd2) ? mperm[s][2] : 1'b0;
    if ({1'b0, s} >= mcnt) return 3'd1;
    if (!mval[s]) return 3'd2;
    if ({1'b0, o} >= mlim[s]) return 3'd3;
    if (!pok) return 3'd4;
    return 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // One cycle: inputs were driven at the falling edge; evaluate, update model, move on.
  task automatic step();
    logic [2:0] c;
    logic [PA_W-1:0] pa;
    bit fire;
    #1;
    chk(stat_ref == mref[stat_idx], "R7", "referenced bit", stat_ref, mref[stat_idx]);
    chk(stat_mod == mmod[stat_idx], "R7", "modified bit", stat_mod, mmod[stat_idx]);
    chk(req_ready == (!rsp_valid || rsp_ready), "R8", "req_ready", req_ready, !rsp_valid || rsp_ready);
    if (last_fire) chk(rsp_valid, "R8", "response after accept", rsp_valid, 1);
    if (prev_stall) begin
      chk(rsp_valid && rsp_paddr == prev_paddr && rsp_cause == prev_cause, "R9",
          "held response", {rsp_cause, rsp_paddr}, {prev_cause, prev_paddr});
    end
    if (rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R8", "unexpected response", 1, 0);
      end else begin
        logic [PA_W+2:0] e;
        e = expq.pop_front();
        chk(rsp_cause == e[PA_W+2:PA_W], tag_of(e[PA_W+2:PA_W]), "cause",
            rsp_cause, e[PA_W+2:PA_W]);
        chk(rsp_paddr == e[PA_W-1:0] && rsp_fault == (e[PA_W+2:PA_W] != 0), "R6",
            "paddr/fault", {rsp_fault, rsp_paddr}, {e[PA_W+2:PA_W] != 0, e[PA_W-1:0]});
      end
    end
    prev_stall = rsp_valid && !rsp_ready;
    prev_paddr = rsp_paddr;
    prev_cause = rsp_cause;
    fire = req_valid && req_ready;
    last_fire = fire;
    if (fire) begin
      // R10: computed from contents before any same-edge write
      c = exp_cause(req_seg, req_off, req_kind);
      pa = (c == 3'd0) ? mbase[req_seg] + PA_W'(req_off) : '0;
      expq.push_back({c, pa});
      if (c == 3'd0) begin
        mref[req_seg] = 1'b1;
        if (req_kind == 2'd1) mmod[req_seg] = 1'b1;
      end
    end
    if (cfg_we) begin
      mbase[cfg_idx] = cfg_base;
      mlim[cfg_idx]  = cfg_limit;
      mperm[cfg_idx] = cfg_perm;
      mval[cfg_idx]  = cfg_valid;
      mref[cfg_idx]  = 1'b0;
      mmod[cfg_idx]  = 1'b0;
    end
    if (cnt_we) mcnt = cnt_val;
    @(negedge clk);
  endtask

  task automatic quiet();
    req_valid = 0; cfg_we = 0; cnt_we = 0; rsp_ready = 1;
  endtask

  task automatic drain();
    quiet();
    repeat (3) step();
  endtask

  task automatic load(input int i, input int b, input int l, input bit v, input int p);
    cfg_we = 1; cfg_idx = SEG_W'(i); cfg_base = PA_W'(b);
    cfg_limit = (OFF_W+1)'(l); cfg_valid = v; cfg_perm = 3'(p);
  endtask

  task automatic ask(input int s, input int o, input int k);
    req_valid = 1; req_seg = SEG_W'(s); req_off = OFF_W'(o); req_kind = 2'(k);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSEG; i++) begin
      mbase[i] = '0; mlim[i] = '0; mperm[i] = '0; mval[i] = 0; mref[i] = 0; mmod[i] = 0;
    end
    mcnt = '0; last_fire = 0; prev_stall = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk(!rsp_valid && req_ready, "R1", "empty channel", {rsp_valid, req_ready}, 2'b01);
    @(negedge clk);
    for (int i = 0; i < NSEG; i++) begin stat_idx = SEG_W'(i); step(); end
    // R1/R2: count is 0, so seg 0 is a bad segment
    ask(0, 0, 0); step(); drain();
    cnt_we = 1; cnt_val = 4'd8; step(); cnt_we = 0;
    load(2, 'h1000, 'h100, 1, 1); stat_idx = 2; step(); cfg_we = 0;
    ask(2, 'hFF, 0); step(); drain();           // R6 ok, R7 ref set
    ask(2, 'h100, 0); step(); drain();          // R4 boundary
    ask(2, 5, 1); step(); drain();              // R5 write not allowed
    ask(2, 5, 3); step(); drain();              // R5 reserved kind
    ask(2, 5, 2); step(); drain();              // R5 exec
    load(3, 0, 0, 0, 7); step(); cfg_we = 0;
    ask(3, 9, 0); step(); drain();              // R3 over limit
    cnt_we = 1; cnt_val = 4'd3; step(); cnt_we = 0;
    ask(3, 9, 0); step(); drain();              // R2 over invalid
    cnt_we = 1; cnt_val = 4'd8; step(); cnt_we = 0;
    load(2, 'h1000, 'h100, 1, 3); step(); cfg_we = 0;
    ask(2, 5, 1); step(); drain();              // R7 write sets modified
    // R10: same-edge rewrite of the entry being translated
    ask(2, 5, 1); load(2, 'h2000, 'h100, 1, 3); step(); drain();
    ask(2, 5, 0); step(); drain();
    // R10: same-edge count write
    ask(2, 6, 0); cnt_we = 1; cnt_val = 4'd1; step(); drain();
    ask(2, 6, 0); step(); drain();
    cnt_we = 1; cnt_val = 4'd8; step(); cnt_we = 0;
    // R6: base wraps modulo 2^PA_W; R4: full-length limit
    load(5, 'hFFF0, 4096, 1, 1); stat_idx = 5; step(); cfg_we = 0;
    ask(5, 'h20, 0); step(); drain();
    ask(5, 'hFFF, 0); step(); drain();
    // R9: back-pressure
    ask(5, 1, 0); rsp_ready = 0; step(); ask(5, 2, 0);
    repeat (4) step();
    rsp_ready = 1; step(); step(); drain();
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int s, lim;
      s = $urandom_range(0, NSEG - 1);
      req_valid = ($urandom_range(0, 3) != 0);
      req_seg = SEG_W'(s);
      lim = int'(mlim[s]);
      case ($urandom_range(0, 3))
        0: req_off = OFF_W'(lim);
        1: req_off = OFF_W'(lim - 1);
        default: req_off = OFF_W'($urandom());
      endcase
      req_kind = 2'($urandom_range(0, 3));
      rsp_ready = ($urandom_range(0, 3) != 0);
      stat_idx = SEG_W'($urandom_range(0, NSEG - 1));
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_idx = ($urandom_range(0, 1) != 0) ? SEG_W'(s) : SEG_W'($urandom_range(0, NSEG - 1));
      cfg_base = PA_W'($urandom());
      cfg_limit = ($urandom_range(0, 4) == 0) ? 13'd4096 : (OFF_W+1)'($urandom_range(0, 4095));
      cfg_valid = ($urandom_range(0, 5) != 0);
      cfg_perm = 3'($urandom());
      cnt_we = ($urandom_range(0, 29) == 0);
      cnt_val = 4'($urandom_range(0, 9));
      step();
    end
    drain();
    chk(expq.size() == 0, "R8", "all responses returned", expq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule